// File: doc/BRIEF.md
# SPI Master Byte Engine with Register Access

This block is an 8-bit SPI master controlled through a small word-wide register bus with four locations: control, clock prescale, status and data. Software sets the serial-clock rate and the clock polarity and phase, enables master operation, and writes a byte to the data location. The engine then runs sixteen SCK edges. It shifts the byte out on MOSI starting with the most significant bit and assembles the byte arriving on MISO.

At the end of a byte the received value is stored in a receive buffer and a completion flag is raised. An interrupt line can follow that flag if both enable bits are set. The flag is cleared by a two-step handshake: first a status read that sees it set, then any access to the data location. Until the status read has happened, data writes are refused, so an unacknowledged byte cannot be overwritten. A low level on the slave-select input forces master operation off, aborts any byte in progress and records a mode fault.

Top module: `serial_link_ctrl`

## Requirements
- R1: After reset all four locations read 0x00, SCK and MOSI are low and the interrupt output is low.
- R2: A data write (address 3) starts a byte when control bit 7 (master) and bit 6 (drive enable) are both set, no byte is running and the completion flag is clear or acknowledged. MOSI carries the written byte MSB first, over exactly 16 SCK edges.
- R3: Control bit 5 is the SCK idle level and holds before and after every byte. Control bit 4 selects the phase. With 0, MISO is sampled on edges 1,3,..,15 and MOSI changes on even edges. With 1, MISO is sampled on edges 2,4,..,16 and MOSI changes on odd edges from the third.
- R4: MISO bits are assembled MSB first and copied to the receive buffer when the byte ends. A data read returns that buffer, also while a later byte is being shifted.
- R5: Each SCK half period lasts (P+1) x 2^D x F system clocks. P is prescale bits 6:0 and D is prescale bit 7. F is 1, 2, 8 or 16 for control bits 3:2 = 00, 01, 10, 11.
- R6: Status bit 7 (completion flag) sets when a byte ends. It clears only on a data read or write that follows a status read made while it was set. A data access without that prior status read leaves it set.
- R7: While the completion flag is set and not yet acknowledged by a status read, a data write is ignored: no SCK activity and no change to the receive buffer.
- R8: The interrupt output is high exactly when the completion flag, control bit 0 (interrupt enable) and control bit 1 (interrupt route) are all set.
- R9: Slave-select low, after a 2-stage synchronizer, clears control bits 7 and 6, aborts a running byte (SCK returns to its idle level, no completion) and, if master was set, sets status bit 6 (mode fault). Status bit 6 clears on a control write that follows a status read made while it was set.
- R10: Data writes are ignored while a byte is running or while master or drive enable is clear.
- R11: Control and prescale locations read back the last value written. Status bits 5:0 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_rd | input | 1 | Read strobe, qualified by bus_sel; triggers read side effects |
| bus_addr | input | 2 | 0 control, 1 prescale, 2 status, 3 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_i | input | 1 | Slave select, low forces master off |
| irq_o | output | 1 | Completion interrupt |

## Verification
The hardest state to reach from the pins is a completion flag that is set but not yet acknowledged while software touches the data location. Polling status would acknowledge the flag, so the stimulus waits for completion on the interrupt line instead. It then issues a data write and a data read, checks that neither starts a byte nor clears the flag, and only afterwards reads status and writes again. A modelled slave on MISO/SCK shifts a known byte on the non-sampling edges, so a wrong phase shows up as corrupted received data. Randomly drawn modes and rates are mixed with a slow rate for a mid-byte read, a write during a byte, and a slave-select abort.

// File: rtl/sl_pkg.sv
package sl_pkg;

    localparam int BYTE_W  = 8;
    localparam int PRESC_W = 7;
    localparam int ADDR_W  = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_CTRL  = 2'd0,
        ADDR_PRESC = 2'd1,
        ADDR_STAT  = 2'd2,
        ADDR_DATA  = 2'd3
    } reg_addr_e;

    // control layout, MSB first
    typedef struct packed {
        logic       mst;       // master operation
        logic       drv_en;    // drive SCK/MOSI
        logic       cpol;      // SCK idle level
        logic       cpha;      // sampling phase
        logic [1:0] rate_sel;  // coarse divider select
        logic       irq_route; // second interrupt qualifier
        logic       irq_en;    // interrupt enable
    } ctrl_t;

    typedef struct packed {
        logic               dbl;   // extra divide by two
        logic [PRESC_W-1:0] pval;  // prescale value, divides by pval+1
    } presc_t;

    // log2 of the coarse factor 1, 2, 8, 16
    function automatic logic [2:0] rate_shift(input logic [1:0] sel);
        case (sel)
            2'd0:    return 3'd0;
            2'd1:    return 3'd1;
            2'd2:    return 3'd3;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/sl_sync.sv
module sl_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/sl_rate_gen.sv
module sl_rate_gen
    import sl_pkg::*;
#(
    parameter int PW = PRESC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic [PW-1:0] pval_i,
    input  logic          dbl_i,
    input  logic [1:0]    rate_sel_i,
    output logic          tick_o
);

    localparam int CW = PW + 6;

    logic [2:0]    sh_w;
    logic [CW-1:0] half_w;
    logic [CW-1:0] cnt_d, cnt_q;

    assign sh_w   = rate_shift(rate_sel_i) + {2'b00, dbl_i};
    assign half_w = (CW'(pval_i) + CW'(1)) << sh_w;
    assign tick_o = run_i && (cnt_q >= half_w - CW'(1));

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i)      cnt_d = '0;
        else if (tick_o) cnt_d = '0;
        else             cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $past(run_i) && $stable(half_w) && $past(cnt_q < half_w)) |-> (cnt_q < half_w)); // R5

endmodule

// File: rtl/sl_shift_engine.sv
module sl_shift_engine #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          abort_i,
    input  logic          tick_i,
    input  logic          cpol_i,
    input  logic          cpha_i,
    input  logic [DW-1:0] data_i,
    input  logic          miso_i,
    output logic          sck_o,
    output logic          mosi_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [DW-1:0] rx_o
);

    localparam int            EDGES = 2 * DW;
    localparam int            EW    = $clog2(EDGES);
    localparam logic [EW-1:0] LAST  = EW'(EDGES - 1);

    typedef struct packed {
        logic          busy;
        logic          sck;
        logic          done;
        logic [EW-1:0] ecnt;
        logic [DW-1:0] tx;
        logic [DW-1:0] rx;
    } eng_t;

    eng_t q, d;
    logic samp_w;

    assign samp_w = cpha_i ? q.ecnt[0] : ~q.ecnt[0];

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (abort_i) begin
            d.busy = 1'b0;
            d.sck  = cpol_i;
        end else if (start_i && !q.busy) begin
            d.busy = 1'b1;
            d.sck  = cpol_i;
            d.ecnt = '0;
            d.tx   = data_i;
            d.rx   = '0;
        end else if (q.busy) begin
            if (tick_i) begin
                d.sck  = ~q.sck;
                d.ecnt = q.ecnt + 1'b1;
                if (samp_w) begin
                    d.rx = {q.rx[DW-2:0], miso_i};
                end else if (!(cpha_i && q.ecnt == '0) && q.ecnt != LAST) begin
                    d.tx = {q.tx[DW-2:0], 1'b0};
                end
                if (q.ecnt == LAST) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end
            end
        end else begin
            d.sck = cpol_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sck_o  = q.sck;
    assign mosi_o = q.tx[DW-1];
    assign busy_o = q.busy;
    assign done_o = q.done;
    assign rx_o   = q.rx;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done); // R6

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.busy && $past(!q.busy) && $stable(cpol_i)) |-> (q.sck == cpol_i)); // R3

endmodule

// File: rtl/serial_link_ctrl.sv
module serial_link_ctrl
    import sl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              sck_o,
    output logic              mosi_o,
    input  logic              miso_i,
    input  logic              ss_n_i,
    output logic              irq_o
);

    typedef struct packed {
        ctrl_t             ctrl;
        presc_t            presc;
        logic [BYTE_W-1:0] rxbuf;
        logic              xfer_done;
        logic              fault;
        logic              ack_done;
        logic              ack_fault;
    } regs_t;

    regs_t q, d;

    logic              ss_sync;
    logic              ss_low;
    logic              wr_ev, rd_ev;
    logic              ctrl_wr, presc_wr, stat_rd, dat_wr, dat_acc;
    logic              start;
    logic              tick;
    logic              eng_sck, eng_mosi, eng_busy, eng_done;
    logic [BYTE_W-1:0] eng_rx;

    sl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ss_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ss_n_i),
        .q_o   (ss_sync)
    );

    assign ss_low   = ~ss_sync;
    assign wr_ev    = bus_sel & bus_wr;
    assign rd_ev    = bus_sel & bus_rd;
    assign ctrl_wr  = wr_ev && (bus_addr == ADDR_CTRL);
    assign presc_wr = wr_ev && (bus_addr == ADDR_PRESC);
    assign stat_rd  = rd_ev && (bus_addr == ADDR_STAT);
    assign dat_wr   = wr_ev && (bus_addr == ADDR_DATA);
    assign dat_acc  = (wr_ev || rd_ev) && (bus_addr == ADDR_DATA);

    assign start = dat_wr && q.ctrl.mst && q.ctrl.drv_en && !ss_low
                && !eng_busy && !eng_done && (!q.xfer_done || q.ack_done);

    always_comb begin
        d = q;
        if (presc_wr) d.presc = presc_t'(bus_wdata);
        if (ctrl_wr) begin
            d.ctrl = ctrl_t'(bus_wdata);
            if (q.ack_fault) begin
                d.fault     = 1'b0;
                d.ack_fault = 1'b0;
            end
        end
        if (stat_rd) begin
            if (q.xfer_done) d.ack_done  = 1'b1;
            if (q.fault)     d.ack_fault = 1'b1;
        end
        if (dat_acc && q.xfer_done && q.ack_done) begin
            d.xfer_done = 1'b0;
            d.ack_done  = 1'b0;
        end
        if (eng_done) begin
            d.xfer_done = 1'b1;
            d.rxbuf     = eng_rx;
        end
        if (ss_low) begin
            d.ctrl.mst    = 1'b0;
            d.ctrl.drv_en = 1'b0;
            if (q.ctrl.mst) begin
                d.fault     = 1'b1;
                d.ack_fault = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    sl_rate_gen #(.PW(PRESC_W)) u_rate (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (eng_busy),
        .pval_i     (q.presc.pval),
        .dbl_i      (q.presc.dbl),
        .rate_sel_i (q.ctrl.rate_sel),
        .tick_o     (tick)
    );

    sl_shift_engine #(.DW(BYTE_W)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .abort_i (ss_low),
        .tick_i  (tick),
        .cpol_i  (q.ctrl.cpol),
        .cpha_i  (q.ctrl.cpha),
        .data_i  (bus_wdata),
        .miso_i  (miso_i),
        .sck_o   (eng_sck),
        .mosi_o  (eng_mosi),
        .busy_o  (eng_busy),
        .done_o  (eng_done),
        .rx_o    (eng_rx)
    );

    always_comb begin
        case (bus_addr)
            ADDR_CTRL:  bus_rdata = q.ctrl;
            ADDR_PRESC: bus_rdata = q.presc;
            ADDR_STAT:  bus_rdata = {q.xfer_done, q.fault, {(BYTE_W-2){1'b0}}};
            default:    bus_rdata = q.rxbuf;
        endcase
    end

    assign sck_o  = eng_sck;
    assign mosi_o = q.ctrl.drv_en & eng_mosi;
    assign irq_o  = q.xfer_done & q.ctrl.irq_en & q.ctrl.irq_route;

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.xfer_done && !dat_acc) |=> q.xfer_done); // R6

    AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.xfer_done && !q.ack_done && dat_wr) |=> !eng_busy); // R7

    AST_RX_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> (q.rxbuf == $past(eng_rx))); // R4

    AST_MODE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_low && q.ctrl.mst) |=> (q.fault && !q.ctrl.mst && !eng_busy)); // R9

endmodule

// File: tb/serial_link_ctrl_tb.sv
module serial_link_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       sck_o, mosi_o, miso_i, irq_o;
    logic       ss_n_i = 1'b1;

    always #10 clk = ~clk;

    serial_link_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i), .ss_n_i(ss_n_i), .irq_o(irq_o)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit summary_done = 1'b0;

    // slave and line monitor
    logic       m_cpha = 1'b0;
    logic       prev_sck = 1'b0;
    int         edge_cnt = 0;
    int         cyc_since = 0;
    int         gap_min = 0, gap_max = 0;
    logic [7:0] slv_sr = 8'd0;
    logic [7:0] mosi_bits = 8'd0;
    logic [7:0] prev_rx = 8'd0;

    assign miso_i = slv_sr[7];

    always @(negedge clk) begin
        cyc_since++;
        if (sck_o !== prev_sck) begin
            edge_cnt++;
            if (edge_cnt >= 2) begin
                if (cyc_since < gap_min) gap_min = cyc_since;
                if (cyc_since > gap_max) gap_max = cyc_since;
            end
            cyc_since = 0;
            if (((edge_cnt % 2) == 0) == m_cpha)
                mosi_bits = {mosi_bits[6:0], mosi_o};
            else if (!(m_cpha && edge_cnt == 1))
                slv_sr = {slv_sr[6:0], 1'b0};
        end
        prev_sck = sck_o;
    end

    function automatic int exp_half(input logic [7:0] c, input logic [7:0] p);
        int f;
        case (c[3:2])
            2'd0:    f = 1;
            2'd1:    f = 2;
            2'd2:    f = 8;
            default: f = 16;
        endcase
        return (int'(p[6:0]) + 1) * (p[7] ? 2 : 1) * f;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic arm(input logic [7:0] c, input logic [7:0] p, input logic [7:0] s);
        wr(2'd0, c);
        wr(2'd1, p);
        idle(3);
        m_cpha    = c[4];
        slv_sr    = s;
        edge_cnt  = 0;
        mosi_bits = 8'd0;
        gap_min   = 1 << 30;
        gap_max   = 0;
    endtask

    task automatic wait_poll(input string req);
        logic [7:0] s;
        bit ok = 1'b0;
        for (int i = 0; i < 10000; i++) begin
            rd(2'd2, s);
            if (s[7]) begin ok = 1'b1; break; end
        end
        chk(req, ok, 1'b1);
    endtask

    task automatic check_done(input logic [7:0] c, input logic [7:0] p,
                              input logic [7:0] tx, input logic [7:0] s);
        logic [7:0] r;
        chk("R2 MOSI byte MSB first", mosi_bits, tx);
        chk("R2 edge count", edge_cnt, 16);
        chk("R3 SCK idle after byte", sck_o, c[5]);
        chk("R5 shortest half period", gap_min, exp_half(c, p));
        chk("R5 longest half period", gap_max, exp_half(c, p));
        chk("R8 interrupt level", irq_o, c[0] & c[1]);
        rd(2'd3, r);
        chk("R4 received byte", r, s);
        rd(2'd2, r);
        chk("R6 flag cleared by status then data", r[7], 1'b0);
        prev_rx = s;
    endtask

    task automatic xfer(input logic [7:0] c, input logic [7:0] p,
                        input logic [7:0] tx, input logic [7:0] s);
        arm(c, p, s);
        wr(2'd3, tx);
        wait_poll("R6 completion flag sets");
        check_done(c, p, tx, s);
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic [7:0] c, p, tx, s;
        bit got;
        void'($urandom(32'd7321));
        idle(4);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], r);
            chk("R1 register reset value", r, 8'h00);
        end
        chk("R1 SCK reset", sck_o, 1'b0);
        chk("R1 MOSI reset", mosi_o, 1'b0);
        chk("R1 IRQ reset", irq_o, 1'b0);

        // R11 readback
        wr(2'd0, 8'h2D); rd(2'd0, r); chk("R11 control readback", r, 8'h2D);
        wr(2'd1, 8'h85); rd(2'd1, r); chk("R11 prescale readback", r, 8'h85);
        rd(2'd2, r); chk("R11 status low bits zero", r, 8'h00);
        wr(2'd0, 8'h00); wr(2'd1, 8'h00);

        // R10 no drive enable
        arm(8'h80, 8'h00, 8'hFF);
        wr(2'd3, 8'hA5);
        idle(50);
        chk("R10 no start without drive enable", edge_cnt, 0);
        rd(2'd2, r); chk("R10 no completion without drive enable", r, 8'h00);

        // random modes and rates
        for (int k = 0; k < 24; k++) begin
            c  = {2'b11, 6'($urandom)};
            p  = {1'($urandom), 5'd0, 2'($urandom % 3)};
            tx = 8'($urandom);
            s  = 8'($urandom);
            xfer(c, p, tx, s);
        end

        // directed corners: fastest rate in phase 1 / polarity 1, largest tested divisor
        xfer(8'hF0, 8'h00, 8'h01, 8'h80);
        xfer(8'hCC, 8'h87, 8'hC3, 8'h3C);
        xfer(8'hC1, 8'h00, 8'hFF, 8'h00);   // R8 route bit clear, no interrupt

        // R4 mid-byte read and R10 write while running
        arm(8'hC4, 8'h01, 8'h3C);
        wr(2'd3, 8'h96);
        idle(10);
        rd(2'd3, r); chk("R4 data read mid-byte returns buffer", r, prev_rx);
        wr(2'd3, 8'h11);
        wait_poll("R10 original byte completes");
        check_done(8'hC4, 8'h01, 8'h96, 8'h3C);
        idle(100);
        chk("R10 write during byte starts nothing", edge_cnt, 16);

        // R6 / R7 handshake without polling
        arm(8'hC3, 8'h00, 8'h81);
        wr(2'd3, 8'h7E);
        got = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (irq_o) begin got = 1'b1; break; end
        end
        chk("R8 interrupt on completion", got, 1'b1);
        edge_cnt = 0;
        wr(2'd3, 8'h00);
        idle(40);
        chk("R7 unacknowledged write starts nothing", edge_cnt, 0);
        chk("R6 flag held after bare data write", irq_o, 1'b1);
        rd(2'd3, r); chk("R7 buffer unchanged", r, 8'h81);
        rd(2'd2, r); chk("R6 flag held after bare data read", r[7], 1'b1);
        arm(8'hC3, 8'h00, 8'h42);
        wr(2'd3, 8'hE7);
        rd(2'd2, r); chk("R6 flag cleared by acknowledged write", r[7], 1'b0);
        wait_poll("R6 completion after acknowledged write");
        check_done(8'hC3, 8'h00, 8'hE7, 8'h42);

        // R9 slave-select abort
        arm(8'hE8, 8'h02, 8'h00);
        wr(2'd3, 8'h55);
        idle(60);
        ss_n_i = 1'b0;
        idle(6);
        chk("R9 SCK back to idle level", sck_o, 1'b1);
        rd(2'd0, r); chk("R9 master and drive cleared", r, 8'h28);
        rd(2'd2, r); chk("R9 mode fault set", r, 8'h40);
        ss_n_i = 1'b1;
        idle(4);
        chk("R9 MOSI released", mosi_o, 1'b0);
        idle(800);
        rd(2'd2, r); chk("R9 aborted byte never completes", r, 8'h40);
        wr(2'd0, 8'hC0);
        rd(2'd2, r); chk("R9 fault cleared by status then control", r, 8'h00);
        rd(2'd0, r); chk("R9 master restored", r, 8'hC0);
        xfer(8'hD5, 8'h01, 8'h6A, 8'hB9);

        summary();
        $finish;
    end

endmodule